// File: doc/BRIEF.md
# Trap Entry and Vectoring Unit

This block decides, in the cycle a trap is raised, which privilege level takes the trap and where execution resumes. It reads the cause word, the faulting PC, the current privilege level and the two delegation masks, and it holds the machine and supervisor trap-vector registers itself. From these it produces a redirect PC, the new privilege level, and write strobes with data for the exception-PC and cause registers of whichever level takes the trap.

Each trap-vector register has a mode flag in bit 0. With the flag clear, every trap goes to the base. With it set, interrupts go to the base plus four times their cause number, and exceptions still go to the base. Software writes to a trap-vector register are legalised as they are stored. The current values are returned on read outputs.

Top module: `trap_entry_unit`

## Requirements
- R1: The top bit of `trap_cause` flags an interrupt, and the lower XLEN-1 bits form the cause number. Interrupts look up `mideleg` and exceptions look up `medeleg`, using the bit indexed by the cause number.
- R2: Privilege encoding is user 2'b00, supervisor 2'b01, machine 2'b11. A trap goes to supervisor only when three conditions hold: `cur_priv` is user or supervisor, the cause number is below XLEN, and the selected delegation bit is 1. In every other case it goes to machine.
- R3: For a machine trap, `redirect_pc` is the machine vector with bit 0 cleared, plus an offset. The offset is the cause number shifted left by two, truncated to XLEN bits, when vector bit 0 is 1 and the trap is an interrupt. In every other case the offset is 0.
- R4: A supervisor trap computes its target the same way, using the supervisor vector.
- R5: On a machine trap, `new_priv` is machine. `mepc_we` and `mcause_we` pulse with `trap_pc` and the full cause word including the interrupt bit. The supervisor strobes stay low.
- R6: On a delegated trap, `new_priv` is supervisor. `sepc_we` and `scause_we` pulse with `trap_pc` and the full cause word. The machine strobes stay low.
- R7: A write with `tvec_wr_en` stores `tvec_wr_data` with bit 1 forced to 0 and all other bits kept. `tvec_wr_sel` 0 selects the machine vector and 1 selects the supervisor vector. The stored value appears on `mtvec_q`/`stvec_q` after the clock edge. Without a write, both vectors hold their values.
- R8: Reset clears both vectors to 0, which means direct mode with base 0.
- R9: All trap outputs are combinational in the cycle `trap_valid` is high. With `trap_valid` low, `redirect_valid` and all strobes are 0, and `new_priv` equals `cur_priv`.
- R10: When a vector write and a trap occur in the same cycle, the trap uses the vector value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_valid | input | 1 | Trap request this cycle |
| trap_cause | input | XLEN | Cause word, top bit = interrupt |
| trap_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege level |
| medeleg | input | XLEN | Exception delegation mask |
| mideleg | input | XLEN | Interrupt delegation mask |
| tvec_wr_en | input | 1 | Trap-vector write strobe |
| tvec_wr_sel | input | 1 | 0 machine vector, 1 supervisor vector |
| tvec_wr_data | input | XLEN | Trap-vector write data |
| redirect_valid | output | 1 | Redirect PC is valid |
| redirect_pc | output | XLEN | Resume address |
| new_priv | output | 2 | Privilege level after the trap |
| mepc_we | output | 1 | Machine exception-PC write |
| mepc_wdata | output | XLEN | Machine exception-PC data |
| mcause_we | output | 1 | Machine cause write |
| mcause_wdata | output | XLEN | Machine cause data |
| sepc_we | output | 1 | Supervisor exception-PC write |
| sepc_wdata | output | XLEN | Supervisor exception-PC data |
| scause_we | output | 1 | Supervisor cause write |
| scause_wdata | output | XLEN | Supervisor cause data |
| mtvec_q | output | XLEN | Machine trap-vector value |
| stvec_q | output | XLEN | Supervisor trap-vector value |

## Verification
The hardest cases to reach are at the delegation boundary. One is a cause number equal to or above XLEN whose low bits point at a set delegation bit. The other is a machine-level trap whose delegation bit is set. In both cases the trap must stay in machine mode. The sweep drives every cause number from 0 to XLEN+2, plus a very large one, for both interrupts and exceptions, at each privilege level. It does this for every combination of vector modes and for a delegation pattern and its complement, so every bit position is seen both set and clear. The same-cycle case pairs a vector write with an interrupt trap. It checks that the target comes from the old vector and that the new vector is used on the next trap.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic            tvec_wr_en,
  input  logic            tvec_wr_sel,
  input  logic [XLEN-1:0] tvec_wr_data,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [1:0]      new_priv,
  output logic            mepc_we,
  output logic [XLEN-1:0] mepc_wdata,
  output logic            mcause_we,
  output logic [XLEN-1:0] mcause_wdata,
  output logic            sepc_we,
  output logic [XLEN-1:0] sepc_wdata,
  output logic            scause_we,
  output logic [XLEN-1:0] scause_wdata,
  output logic [XLEN-1:0] mtvec_q,
  output logic [XLEN-1:0] stvec_q
);
  localparam int IW = $clog2(XLEN);
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  logic [XLEN-1:0] mtvec_r, stvec_r;
  logic [XLEN-1:0] tvec_legal;

  assign tvec_legal = {tvec_wr_data[XLEN-1:2], 1'b0, tvec_wr_data[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mtvec_r <= '0;
      stvec_r <= '0;
    end else if (tvec_wr_en) begin
      if (tvec_wr_sel) stvec_r <= tvec_legal;
      else             mtvec_r <= tvec_legal;
    end
  end

  assign mtvec_q = mtvec_r;
  assign stvec_q = stvec_r;

  logic            is_intr;
  logic [XLEN-1:0] cause_num;
  logic [XLEN-1:0] deleg_src;
  logic            num_in_range;
  logic            to_super;
  logic [XLEN-1:0] tvec_sel;
  logic [XLEN-1:0] vec_off;

  assign is_intr      = trap_cause[XLEN-1];
  assign cause_num    = {1'b0, trap_cause[XLEN-2:0]};
  assign deleg_src    = is_intr ? mideleg : medeleg;
  assign num_in_range = (cause_num[XLEN-1:IW] == '0);
  assign to_super     = (cur_priv <= PRIV_S) && num_in_range && deleg_src[cause_num[IW-1:0]];

  assign tvec_sel = to_super ? stvec_r : mtvec_r;
  assign vec_off  = (tvec_sel[0] && is_intr) ? (cause_num << 2) : '0;

  assign redirect_valid = trap_valid;
  assign redirect_pc    = {tvec_sel[XLEN-1:1], 1'b0} + vec_off;
  assign new_priv       = !trap_valid ? cur_priv : (to_super ? PRIV_S : PRIV_M);

  assign mepc_we      = trap_valid && !to_super;
  assign mcause_we    = trap_valid && !to_super;
  assign sepc_we      = trap_valid && to_super;
  assign scause_we    = trap_valid && to_super;
  assign mepc_wdata   = trap_pc;
  assign sepc_wdata   = trap_pc;
  assign mcause_wdata = trap_cause;
  assign scause_wdata = trap_cause;

  AST_M_TRAP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we |-> (new_priv == PRIV_M && mcause_we && !sepc_we && !scause_we)); // R5
  AST_S_TRAP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sepc_we |-> (cur_priv <= PRIV_S && new_priv == PRIV_S && scause_we && !mepc_we)); // R6
  AST_TVEC_BIT1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mtvec_q[1] == 1'b0) && (stvec_q[1] == 1'b0)); // R7
  AST_TVEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tvec_wr_en |=> ($stable(mtvec_q) && $stable(stvec_q))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> !(redirect_valid || mepc_we || mcause_we || sepc_we || scause_we)); // R9
endmodule

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;
  localparam int XLEN = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 1'b0;
  logic [XLEN-1:0] trap_cause = '0, trap_pc = '0, medeleg = '0, mideleg = '0, tvec_wr_data = '0;
  logic [1:0] cur_priv = 2'b11;
  logic tvec_wr_en = 1'b0, tvec_wr_sel = 1'b0;
  logic redirect_valid, mepc_we, mcause_we, sepc_we, scause_we;
  logic [XLEN-1:0] redirect_pc, mepc_wdata, mcause_wdata, sepc_wdata, scause_wdata, mtvec_q, stvec_q;
  logic [1:0] new_priv;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [XLEN-1:0] mtv_model = '0, stv_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN)) i_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_pc(trap_pc), .cur_priv(cur_priv), .medeleg(medeleg), .mideleg(mideleg),
    .tvec_wr_en(tvec_wr_en), .tvec_wr_sel(tvec_wr_sel), .tvec_wr_data(tvec_wr_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .new_priv(new_priv),
    .mepc_we(mepc_we), .mepc_wdata(mepc_wdata), .mcause_we(mcause_we), .mcause_wdata(mcause_wdata),
    .sepc_we(sepc_we), .sepc_wdata(sepc_wdata), .scause_we(scause_we), .scause_wdata(scause_wdata),
    .mtvec_q(mtvec_q), .stvec_q(stvec_q));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_tvec(input bit sel, input logic [XLEN-1:0] d);
    @(negedge clk);
    tvec_wr_en = 1'b1; tvec_wr_sel = sel; tvec_wr_data = d;
    @(negedge clk);
    tvec_wr_en = 1'b0;
    if (sel) stv_model = d & ~32'h2; else mtv_model = d & ~32'h2;
    #1;
    chk(mtvec_q == mtv_model, "R7 mtvec", mtvec_q, mtv_model);
    chk(stvec_q == stv_model, "R7 stvec", stvec_q, stv_model);
  endtask

  task automatic trap_check(input logic [1:0] p, input logic [XLEN-1:0] cause, input logic [XLEN-1:0] pc);
    logic intr, del;
    logic [XLEN-1:0] num, dsrc, tv, exp_pc;
    logic [1:0] exp_priv;
    @(negedge clk);
    cur_priv = p; trap_cause = cause; trap_pc = pc; trap_valid = 1'b1;
    #1;
    intr = cause[XLEN-1];
    num = cause & 32'h7FFF_FFFF;
    dsrc = intr ? mideleg : medeleg;
    del = (p == 2'b00 || p == 2'b01) && (num < XLEN) && dsrc[num % XLEN];
    tv = del ? stv_model : mtv_model;
    exp_pc = (tv & ~32'h1) + ((tv[0] && intr) ? num * 4 : 32'h0);
    exp_priv = del ? 2'b01 : 2'b11;
    chk(redirect_valid && redirect_pc == exp_pc, del ? "R4 target" : "R3 target", redirect_pc, exp_pc);
    chk(new_priv == exp_priv, "R2 R1 priv", new_priv, exp_priv);
    if (del)
      chk(sepc_we && scause_we && !mepc_we && !mcause_we && sepc_wdata == pc && scause_wdata == cause,
          "R6 strobes", {sepc_we, scause_we, mepc_we, mcause_we, scause_wdata}, {4'b1100, cause});
    else
      chk(mepc_we && mcause_we && !sepc_we && !scause_we && mepc_wdata == pc && mcause_wdata == cause,
          "R5 strobes", {mepc_we, mcause_we, sepc_we, scause_we, mcause_wdata}, {4'b1100, cause});
    trap_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] privs [3];
    privs[0] = 2'b00; privs[1] = 2'b01; privs[2] = 2'b11;
    #1;
    chk(mtvec_q == '0 && stvec_q == '0, "R8 reset vectors", {mtvec_q, stvec_q}, 64'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    trap_check(2'b11, 32'h0000_0005, 32'h1234_5678);
    @(negedge clk);
    cur_priv = 2'b01; #1;
    chk(!redirect_valid && !mepc_we && !mcause_we && !sepc_we && !scause_we && new_priv == 2'b01,
        "R9 idle", {redirect_valid, mepc_we, sepc_we, new_priv}, {3'b000, 2'b01});
    write_tvec(1'b0, 32'hFFFF_FFFF);
    write_tvec(1'b1, 32'h8000_0002);
    for (int cfg = 0; cfg < 4; cfg++) begin
      write_tvec(1'b0, 32'h8000_1002 | cfg[0]);
      write_tvec(1'b1, 32'h4000_0202 | cfg[1]);
      for (int dp = 0; dp < 2; dp++) begin
        medeleg = dp ? ~32'hA5A5_0F3C : 32'hA5A5_0F3C;
        mideleg = dp ? ~32'h0000_0222 : 32'h0000_0222;
        for (int pi = 0; pi < 3; pi++)
          for (int it = 0; it < 2; it++) begin
            for (int n = 0; n < XLEN + 3; n++)
              trap_check(privs[pi], {it[0], 31'(n)}, 32'h0000_4000 + n);
            trap_check(privs[pi], {it[0], 31'h7FFF_FFFF}, 32'hDEAD_BEE0);
          end
      end
    end
    write_tvec(1'b0, 32'h0000_0101);
    medeleg = '0; mideleg = '0;
    @(negedge clk);
    cur_priv = 2'b11; trap_cause = 32'h8000_0003; trap_pc = 32'h100; trap_valid = 1'b1;
    tvec_wr_en = 1'b1; tvec_wr_sel = 1'b0; tvec_wr_data = 32'h0000_2001;
    #1;
    chk(redirect_pc == 32'h0000_010C, "R10 old vector", redirect_pc, 32'h0000_010C);
    @(negedge clk);
    tvec_wr_en = 1'b0; trap_valid = 1'b0;
    mtv_model = 32'h0000_2001;
    trap_check(2'b11, 32'h8000_0003, 32'h200);
    chk(redirect_pc == 32'h0000_200C, "R10 new vector", redirect_pc, 32'h0000_200C);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule